// File: doc/BRIEF.md
# Instruction Line Alignment Buffer

This block sits between a 128-bit instruction fetch path and the decode stage. Fetch presents a quad of four 32-bit instruction words, and the first word of each quad sits at an address that is a multiple of four. Each word carries an end-of-line bit. The block stores the words in a five-slot FIFO and regroups them into execution lines of one to four words. It presents each complete line to decode with its words left-justified and a word count.

A line that runs across two fetch quads is held back until the quad that carries its last word has arrived. The FIFO holds only five words, so a leftover partial line and a whole new quad may not fit together. In that case the block moves as many lanes of the presented quad as there are free slots. The quad stays presented until its last lane has moved, and the block asserts fetch-ready only in that cycle.

A flush input empties the FIFO in one cycle to support redirection. The first quad after reset or flush may begin part-way through the quad: a start-offset input gives the number of leading lanes to discard.

The controller has three states:
- `LAB_RESYNC` is entered on reset or flush. In this state the start offset applies to the next quad.
- `LAB_STREAM` means the block is at a quad boundary.
- `LAB_SPLIT` means part of the presented quad has already moved into the FIFO.

The transitions are:
- Any state goes to `LAB_RESYNC` on flush.
- `LAB_RESYNC` or `LAB_STREAM` goes to `LAB_STREAM` when the whole remainder of the quad fits, and to `LAB_SPLIT` when only part of it fits.
- `LAB_SPLIT` goes to `LAB_STREAM` when the rest of the quad fits, and otherwise stays in `LAB_SPLIT`.

Top module: `line_align_buf`

## Requirements
- R1: Lanes of a presented quad move into the FIFO in lane order, limited to the free slots (FIFO depth minus stored words, counted before this cycle's pop). fetch_ready is high only in the cycle in which the last remaining lane moves, and never while fetch_valid is low. While fetch_ready is low, the quad must stay presented unchanged.
- R2: A line is the oldest stored words up to and including the first word whose end-of-line bit (fetch_eol[k] for lane k) is set, searched within the oldest four words. out_valid is high exactly when such a line is fully stored, and out_cnt gives its length, 1 to 4.
- R3: Line word 0 appears on out_data[31:0], word 1 on out_data[63:32], and so on. Lanes at or above out_cnt are zero, and out_data and out_cnt are zero while out_valid is low.
- R4: A line is removed on a clock edge where out_valid and out_ready are both high. Lines leave in program order with no word lost or repeated, across quad boundaries.
- R5: While the terminating word of the oldest line has not yet been stored, out_valid stays low.
- R6: When four words are stored with no end-of-line bit among them, they are issued as a four-word line with out_err high. out_err is low for every line that ends on a set bit, including a four-word one.
- R7: In a cycle with flush high, out_valid and fetch_ready are low. After the flush edge the FIFO is empty and any partly moved quad is abandoned.
- R8: For the first quad after reset or flush, lanes below fetch_skip are discarded. For every later quad, fetch_skip is ignored.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_cnt hold their values.
- R10: After reset the FIFO is empty: out_valid, out_err, out_cnt and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the FIFO and resynchronise on the next quad |
| fetch_valid | input | 1 | A fetch quad is presented |
| fetch_ready | output | 1 | The last remaining lane of the quad moves this cycle |
| fetch_data | input | 128 | Four instruction words, lane 0 in bits 31:0 |
| fetch_eol | input | 4 | End-of-line bit per lane |
| fetch_skip | input | 2 | Leading lanes to discard on the first quad after reset or flush |
| out_valid | output | 1 | A complete line is presented |
| out_ready | input | 1 | Decode takes the line |
| out_data | output | 128 | Line words, left-justified, unused lanes zero |
| out_cnt | output | 3 | Number of words in the line (1 to 4) |
| out_err | output | 1 | Line was forced after four words without an end-of-line bit |

## Verification
The outputs are combinational from the stored words. A line completed by lanes that move on edge E is visible in the cycle after E, and it leaves on the first later edge at which out_ready is high. fetch_ready is combinational from the stored fill, the controller state and fetch_valid, so it is decided within the cycle in which the quad is presented. The bench drives inputs just after a rising edge and samples every output at the falling edge. A line seen valid and ready at a falling edge is scored as taken on the following rising edge. A reference model fed with each presented quad predicts the line sequence, so the scoreboard stays correct however the lanes of a quad are split across cycles.

// File: rtl/lab_pkg.sv
package lab_pkg;
    parameter int unsigned LAB_WORD_W = 32;

    typedef struct packed {
        logic                  eol;
        logic [LAB_WORD_W-1:0] data;
    } lab_slot_t;

    typedef enum logic [1:0] {
        LAB_RESYNC = 2'd0,
        LAB_STREAM = 2'd1,
        LAB_SPLIT  = 2'd2
    } lab_state_e;
endpackage

// File: rtl/lab_fetch_ctrl.sv
module lab_fetch_ctrl #(
    parameter int FETCH_N = 4,
    parameter int DEPTH   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        fetch_valid,
    input  logic [$clog2(FETCH_N)-1:0]  fetch_skip,
    input  logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        fetch_ready,
    output logic [$clog2(FETCH_N+1)-1:0] lane_start,
    output logic [$clog2(FETCH_N+1)-1:0] lane_take
);
    import lab_pkg::*;

    localparam int LANE_W = $clog2(FETCH_N + 1);

    lab_state_e        state_q, state_d;
    logic [LANE_W-1:0] taken_q, taken_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LAB_RESYNC;
            taken_q <= '0;
        end else begin
            state_q <= state_d;
            taken_q <= taken_d;
        end
    end

    // outputs and next state
    always_comb begin
        int start_i;
        int avail_i;
        int free_i;
        int take_i;
        logic fits;

        free_i = DEPTH - int'(fill);
        unique case (state_q)
            LAB_RESYNC: start_i = int'(fetch_skip);
            LAB_STREAM: start_i = 0;
            LAB_SPLIT:  start_i = int'(taken_q);
            default:    start_i = 0;
        endcase
        avail_i = FETCH_N - start_i;
        fits    = (free_i >= avail_i);

        if (flush || !fetch_valid) begin
            take_i = 0;
        end else begin
            take_i = fits ? avail_i : free_i;
        end

        fetch_ready = !flush && fetch_valid && fits;
        lane_start  = LANE_W'(start_i);
        lane_take   = LANE_W'(take_i);

        state_d = state_q;
        taken_d = taken_q;
        if (flush) begin
            state_d = LAB_RESYNC;
            taken_d = '0;
        end else if (fetch_ready) begin
            state_d = LAB_STREAM;
            taken_d = '0;
        end else if (take_i > 0) begin
            state_d = LAB_SPLIT;
            taken_d = LANE_W'(start_i + take_i);
        end
    end
endmodule

// File: rtl/lab_slot_store.sv
module lab_slot_store #(
    parameter int FETCH_N  = 4,
    parameter int DEPTH    = 5,
    parameter int MAX_LINE = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   flush,
    input  lab_pkg::lab_slot_t [FETCH_N-1:0]       lanes,
    input  logic [$clog2(FETCH_N+1)-1:0]           lane_start,
    input  logic [$clog2(FETCH_N+1)-1:0]           lane_take,
    input  logic [$clog2(MAX_LINE+1)-1:0]          pop_n,
    output logic [$clog2(DEPTH+1)-1:0]             fill,
    output lab_pkg::lab_slot_t [MAX_LINE-1:0]      head
);
    import lab_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    lab_slot_t [DEPTH-1:0] mem_q, mem_d;
    logic [CNT_W-1:0]      fill_q, fill_d;

    always_comb begin
        int base;
        int src;
        int first;
        int last;
        base  = int'(fill_q) - int'(pop_n);
        first = int'(lane_start);
        last  = int'(lane_start) + int'(lane_take);
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = '0;
            src = i + int'(pop_n);
            if (src < int'(fill_q)) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == src) mem_d[i] = mem_q[j];
                end
            end else begin
                for (int k = 0; k < FETCH_N; k++) begin
                    if (k >= first && k < last && i == base + k - first)
                        mem_d[i] = lanes[k];
                end
            end
        end
        fill_d = CNT_W'(base + int'(lane_take));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mem_q  <= '0;
            fill_q <= '0;
        end else begin
            mem_q  <= mem_d;
            fill_q <= fill_d;
        end
    end

    always_comb begin
        for (int i = 0; i < MAX_LINE; i++) head[i] = mem_q[i];
    end

    assign fill = fill_q;
endmodule

// File: rtl/lab_line_pick.sv
module lab_line_pick #(
    parameter int DEPTH    = 5,
    parameter int MAX_LINE = 4
) (
    input  lab_pkg::lab_slot_t [MAX_LINE-1:0]             head,
    input  logic [$clog2(DEPTH+1)-1:0]                    fill,
    output logic                                          line_ok,
    output logic                                          forced,
    output logic [$clog2(MAX_LINE+1)-1:0]                 len,
    output logic [MAX_LINE*lab_pkg::LAB_WORD_W-1:0]       data
);
    import lab_pkg::*;

    localparam int LEN_W = $clog2(MAX_LINE + 1);
    localparam int W     = LAB_WORD_W;

    always_comb begin
        int len_i;
        len_i   = 0;
        line_ok = 1'b0;
        forced  = 1'b0;
        for (int i = 0; i < MAX_LINE; i++) begin
            if (!line_ok && i < int'(fill) && head[i].eol) begin
                line_ok = 1'b1;
                len_i   = i + 1;
            end
        end
        if (!line_ok && int'(fill) >= MAX_LINE) begin
            line_ok = 1'b1;
            forced  = 1'b1;
            len_i   = MAX_LINE;
        end
        len  = LEN_W'(len_i);
        data = '0;
        for (int i = 0; i < MAX_LINE; i++) begin
            if (i < len_i) data[i*W +: W] = head[i].data;
        end
    end
endmodule

// File: rtl/line_align_buf.sv
module line_align_buf #(
    parameter int FETCH_N  = 4,
    parameter int DEPTH    = 5,
    parameter int MAX_LINE = 4,
    localparam int W       = lab_pkg::LAB_WORD_W,
    localparam int SKIP_W  = $clog2(FETCH_N),
    localparam int LEN_W   = $clog2(MAX_LINE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    fetch_valid,
    output logic                    fetch_ready,
    input  logic [FETCH_N*W-1:0]    fetch_data,
    input  logic [FETCH_N-1:0]      fetch_eol,
    input  logic [SKIP_W-1:0]       fetch_skip,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [MAX_LINE*W-1:0]   out_data,
    output logic [LEN_W-1:0]        out_cnt,
    output logic                    out_err
);
    import lab_pkg::*;

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LANE_W = $clog2(FETCH_N + 1);

    lab_slot_t [FETCH_N-1:0]  lanes;
    lab_slot_t [MAX_LINE-1:0] head;
    logic [CNT_W-1:0]         fill;
    logic [LANE_W-1:0]        lane_start, lane_take;
    logic [LEN_W-1:0]         len, pop_n;
    logic                     line_ok, forced;
    logic [MAX_LINE*W-1:0]    line_data;

    for (genvar k = 0; k < FETCH_N; k++) begin : g_lane
        assign lanes[k] = '{eol: fetch_eol[k], data: fetch_data[k*W +: W]};
    end

    lab_fetch_ctrl #(.FETCH_N(FETCH_N), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fetch_valid(fetch_valid),
        .fetch_skip (fetch_skip),
        .fill       (fill),
        .fetch_ready(fetch_ready),
        .lane_start (lane_start),
        .lane_take  (lane_take)
    );

    lab_slot_store #(.FETCH_N(FETCH_N), .DEPTH(DEPTH), .MAX_LINE(MAX_LINE)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lanes     (lanes),
        .lane_start(lane_start),
        .lane_take (lane_take),
        .pop_n     (pop_n),
        .fill      (fill),
        .head      (head)
    );

    lab_line_pick #(.DEPTH(DEPTH), .MAX_LINE(MAX_LINE)) u_pick (
        .head   (head),
        .fill   (fill),
        .line_ok(line_ok),
        .forced (forced),
        .len    (len),
        .data   (line_data)
    );

    assign out_valid = line_ok && !flush;
    assign out_cnt   = out_valid ? len : '0;
    assign out_data  = out_valid ? line_data : '0;
    assign out_err   = out_valid && forced;
    assign pop_n     = (out_valid && out_ready) ? len : '0;
endmodule

// File: rtl/lab_align_checker.sv
module lab_align_checker #(
    parameter int DEPTH    = 5,
    parameter int MAX_LINE = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              flush,
    input logic                              fetch_valid,
    input logic                              fetch_ready,
    input logic                              out_valid,
    input logic                              out_ready,
    input logic [MAX_LINE*32-1:0]            out_data,
    input logic [$clog2(MAX_LINE+1)-1:0]     out_cnt,
    input logic                              out_err,
    input logic [$clog2(DEPTH+1)-1:0]        fill
);
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH);

    a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_valid);

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cnt != '0 && int'(out_cnt) <= MAX_LINE));

    a_r6_err_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && int'(out_cnt) == MAX_LINE));

    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!fetch_ready && !out_valid));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !out_valid));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) ##1 !flush |->
            (out_valid && $stable(out_data) && $stable(out_cnt)));
endmodule

bind line_align_buf lab_align_checker #(.DEPTH(DEPTH), .MAX_LINE(MAX_LINE)) u_lab_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_cnt    (out_cnt),
    .out_err    (out_err),
    .fill       (fill)
);

// File: tb/test_line_align_buf.sv
module test_line_align_buf;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [127:0] data;
        logic [2:0]   cnt;
        logic         err;
    } exp_t;

    typedef struct packed {
        logic        eol;
        logic [31:0] data;
    } word_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         fetch_valid = 1'b0;
    logic         fetch_ready;
    logic [127:0] fetch_data = '0;
    logic [3:0]   fetch_eol = '0;
    logic [1:0]   fetch_skip = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic [2:0]   out_cnt;
    logic         out_err;

    int    checks = 0;
    int    errors = 0;
    int    seq = 0;
    bit    resync = 1'b1;
    bit    done = 1'b0;
    word_t pend[$];
    exp_t  exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_align_buf i_line_align_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_data(fetch_data), .fetch_eol(fetch_eol), .fetch_skip(fetch_skip),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_cnt(out_cnt), .out_err(out_err)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // reference model: cut lines from the pending word list
    task automatic extract();
        forever begin
            int n, found, len;
            exp_t e;
            n = pend.size();
            found = -1;
            for (int i = 0; i < 4 && i < n; i++)
                if (found < 0 && pend[i].eol) found = i;
            if (found >= 0) begin
                len = found + 1; e.err = 1'b0;
            end else if (n >= 4) begin
                len = 4; e.err = 1'b1;
            end else break;
            e.data = '0;
            e.cnt  = 3'(len);
            for (int i = 0; i < len; i++) e.data[i*32 +: 32] = pend[i].data;
            for (int i = 0; i < len; i++) void'(pend.pop_front());
            exp_q.push_back(e);
        end
    endtask

    // driver: model the quad, then hold it until fetch_ready
    task automatic present(input logic [3:0] eol, input int skip);
        @(posedge clk); #1;
        for (int k = 0; k < 4; k++) begin
            fetch_data[k*32 +: 32] = 32'hC000_0000 + 32'(seq);
            if (!resync || k >= skip) pend.push_back('{eol: eol[k], data: 32'hC000_0000 + 32'(seq)});
            seq++;
        end
        resync     = 1'b0;
        extract();
        fetch_eol  = eol;
        fetch_skip = 2'(skip);
        fetch_valid = 1'b1;
        do @(negedge clk); while (!fetch_ready);
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 300) begin
            @(negedge clk); guard++;
        end
        check(exp_q.size() == 0, "R4 all lines delivered", 128'(exp_q.size()), 0);
    endtask

    // monitor / scoreboard: a line valid and ready at negedge is taken next edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && !flush) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected line", out_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.data, "R3 line words", out_data, e.data);
                check(out_cnt == e.cnt, "R2 line count", 128'(out_cnt), 128'(e.cnt));
                check(out_err == e.err, "R6 error flag", 128'(out_err), 128'(e.err));
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [127:0] held;
        logic [7:0]   lf;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", 128'(out_valid), 0);
        check(out_err == 1'b0, "R10 out_err after reset", 128'(out_err), 0);
        check(out_cnt == 3'd0 && out_data == '0, "R10 empty output", out_data, 0);
        check(fetch_ready == 1'b0, "R1 no ready without valid", 128'(fetch_ready), 0);

        // single-word lines
        present(4'b1111, 0);
        drain();

        // line straddling two quads (R5), exact four-word line with eol (R6)
        present(4'b0010, 0);
        @(negedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R5 partial line held", 128'(out_valid), 0);
        present(4'b1001, 0);
        present(4'b1000, 0);
        drain();

        // forced line without end-of-line (R6)
        present(4'b0000, 0);
        present(4'b1111, 0);
        drain();

        // backpressure: split quad (R1) and held output (R9)
        out_ready = 1'b0;
        present(4'b1111, 0);
        fork
            present(4'b1111, 0);
            begin
                @(negedge clk);
                held = out_data;
                for (int c = 0; c < 3; c++) begin
                    check(fetch_ready == 1'b0, "R1 quad waits for room", 128'(fetch_ready), 0);
                    check(out_valid && out_data == held, "R9 output held", out_data, held);
                    @(negedge clk);
                end
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join
        drain();

        // flush then start offset (R7, R8)
        out_ready = 1'b0;
        present(4'b0100, 0);
        @(posedge clk); #1 flush = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 no output during flush", 128'(out_valid), 0);
        check(fetch_ready == 1'b0, "R7 no ready during flush", 128'(fetch_ready), 0);
        @(posedge clk); #1 flush = 1'b0;
        pend.delete(); exp_q.delete(); resync = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 buffer empty after flush", 128'(out_valid), 0);
        out_ready = 1'b1;
        present(4'b1111, 2);
        present(4'b1111, 3);
        drain();

        // mixed stream with toggling out_ready
        lf = 8'h5B;
        fork
            begin
                for (int q = 0; q < 40; q++) begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    present(lf[3:0], 0);
                end
            end
            begin
                for (int t = 0; t < 200; t++) begin
                    @(posedge clk); #1 out_ready = (t % 3) != 1;
                end
                out_ready = 1'b1;
            end
        join
        drain();

        finish_run();
    end
endmodule